// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Fill Thresholds

This block is a first-in first-out queue of 9-bit words. It sits between a producer running on its own write clock and a consumer running on a read clock. The two clocks may be unrelated, or the same net may drive both. The depth is a parameter and takes one of four sizes: 512, 1024, 2048 or 4096 words. The storage is an inferred two-port array. Both pointers cross between the domains as Gray codes through two-flop synchronizers, and each pointer carries one extra wrap bit so that a full queue can be told apart from an empty one.

Four active-low flags report the fill state. The full and almost-full flags live in the write domain. The empty and almost-empty flags live in the read domain. Each almost flag compares the fill level against its own threshold register. Both thresholds reset to 7. The producer can reload them through the write port. To do so, it holds the shared load pin high while reset is released, and every qualified write-clock edge then loads a threshold instead of storing a word. The loads alternate between the two thresholds.

An output enable gates the read data and its valid strobe without stopping the read pointer.

Top module: `dcfifo_pf`

## Requirements
- R1: While reset is low, and after its release, emptyN=0, fullN=1, almostEmptyN=0, almostFullN=1 and dataValid=0.
- R2: Words come out on dataOut in the same order they were written.
- R3: After DEPTH stored words, fullN=0. Further writes are ignored, and the stored contents read back unchanged.
- R4: A read while emptyN=0 returns nothing (dataValid stays 0) and does not disturb the read pointer. A later write and read still pair up correctly.
- R5: In normal mode, a word is stored only on a write-clock edge where wrEnA=1 and wrEnLd=1 and fullN=1. Either enable alone stores nothing.
- R6: A word is fetched only on a read-clock edge where rdEnA=1 and rdEnB=1 and emptyN=1. Either enable alone fetches nothing.
- R7: With the reset thresholds, almostEmptyN=0 while the fill level is 7 or less, and almostEmptyN=1 at a level of 8.
- R8: With the reset thresholds, almostFullN=0 while the fill level is DEPTH-7 or more, and almostFullN=1 at DEPTH-8.
- R9: The level of wrEnLd at the first write-clock edge after reset release selects the mode: 1 selects load mode, 0 selects normal mode. That edge stores nothing. In load mode:
  - an edge with wrEnA=1 and wrEnLd=1 loads wrData (zero-extended) into a threshold, taking the almost-empty threshold first, then the almost-full one, then the almost-empty one again;
  - an edge with wrEnA=1 and wrEnLd=0 stores a word.
- R10: While outEn=0, dataOut is 0 and dataValid is 0, but a qualified read still consumes a word.
- R11: One read-clock edge after a fetch with outEn=1, dataValid=1 and dataOut holds the fetched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| rdClk | input | 1 | Read-domain clock |
| rstN | input | 1 | Asynchronous active-low reset shared by both domains |
| wrData | input | 9 | Word to store, or threshold value in load mode |
| wrEnA | input | 1 | Primary write enable, active high |
| wrEnLd | input | 1 | Second write enable in normal mode; load select in load mode |
| fullN | output | 1 | Low when the queue holds DEPTH words |
| almostFullN | output | 1 | Low when the level is at or above DEPTH minus the almost-full threshold |
| rdEnA | input | 1 | First read enable, active high |
| rdEnB | input | 1 | Second read enable, active high |
| outEn | input | 1 | Output enable for dataOut and dataValid |
| dataOut | output | 9 | Last fetched word, forced to zero when outEn is low |
| dataValid | output | 1 | High for the cycle after a fetch when outEn is high |
| emptyN | output | 1 | Low when the queue holds no word |
| almostEmptyN | output | 1 | Low when the level is at or below the almost-empty threshold |

## Verification
The bench builds the block at the default DEPTH of 512. This is the smallest legal size, so filling the queue to its full boundary and past its almost-full boundary takes only a few hundred writes. At this depth the 9-bit data word also spans the full threshold width, so any threshold loaded through the data port is in range. The two clocks share the 20 ns period but run with a fixed phase offset, which keeps the synchronizer paths exercised as they would be between truly separate domains.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;

  // Strobe from write control to the datapath
  typedef struct packed {
    logic write;
  } wrCmd_t;

  // Strobe from read control to the datapath
  typedef struct packed {
    logic read;
  } rdCmd_t;

endpackage

// File: rtl/fifo_pf_sync2.sv
module fifo_pf_sync2 #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/fifo_pf_wrctl.sv
module fifo_pf_wrctl
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rstN,
  input  logic          wrEnA,
  input  logic          wrEnLd,
  input  logic [WIDTH-1:0] wrData,
  input  logic [PW-1:0] rdGraySync,
  output wrCmd_t        wrCmd,
  output logic [AW-1:0] wrAddr,
  output logic [PW-1:0] wrGray,
  output logic [AW-1:0] aeOff,
  output logic          fullN,
  output logic          almostFullN
);
  logic          armed;
  logic          loadMode;
  logic          ldSel;
  logic          ldAe;
  logic          ldAf;
  logic [AW-1:0] afOff;
  logic [PW-1:0] wrBin;
  logic [PW-1:0] wrBinNext;
  logic [PW-1:0] wrGrayNext;
  logic [PW-1:0] rdBinSync;
  logic [PW-1:0] level;
  logic [PW-1:0] afLimit;

  // Qualify the write and load strobes for the current mode
  always_comb begin
    wrCmd.write = !armed && wrEnA && (loadMode ? !wrEnLd : wrEnLd) && fullN;
    ldAe        = !armed && loadMode && wrEnA && wrEnLd && !ldSel;
    ldAf        = !armed && loadMode && wrEnA && wrEnLd && ldSel;
  end

  assign wrBinNext  = wrBin + PW'(wrCmd.write);
  assign wrGrayNext = (wrBinNext >> 1) ^ wrBinNext;
  assign wrAddr     = wrBin[AW-1:0];

  // Gray to binary for the read pointer seen in this domain
  always_comb begin
    for (int i = 0; i < PW; i++) begin
      rdBinSync[i] = ^(rdGraySync >> i);
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b1;
      loadMode <= 1'b0;
      ldSel    <= 1'b0;
      aeOff    <= AW'(7);
      afOff    <= AW'(7);
      wrBin    <= '0;
      wrGray   <= '0;
      fullN    <= 1'b1;
    end else begin
      if (armed) begin
        armed    <= 1'b0;
        loadMode <= wrEnLd;
      end
      if (ldAe) begin
        aeOff <= AW'(wrData);
        ldSel <= 1'b1;
      end
      if (ldAf) begin
        afOff <= AW'(wrData);
        ldSel <= 1'b0;
      end
      wrBin  <= wrBinNext;
      wrGray <= wrGrayNext;
      fullN  <= !(wrGrayNext == {~rdGraySync[PW-1:PW-2], rdGraySync[PW-3:0]});
    end
  end

  assign level       = wrBin - rdBinSync;
  assign afLimit     = PW'(DEPTH) - PW'(afOff);
  assign almostFullN = !(level >= afLimit);

  a_r3_no_overflow: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |=> (wrBin == $past(wrBin)));

  a_r3_level_bound: assert property (@(posedge wrClk) disable iff (!rstN)
    level <= PW'(DEPTH));

  a_r9_load_keeps_ptr: assert property (@(posedge wrClk) disable iff (!rstN)
    (ldAe || ldAf) |=> (wrBin == $past(wrBin)));

  a_r9_mode_edge_idle: assert property (@(posedge wrClk) disable iff (!rstN)
    armed |=> (wrBin == $past(wrBin)));
endmodule

// File: rtl/fifo_pf_rdctl.sv
module fifo_pf_rdctl
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          rdEnA,
  input  logic          rdEnB,
  input  logic [PW-1:0] wrGraySync,
  input  logic [AW-1:0] aeOff,
  output rdCmd_t        rdCmd,
  output logic [AW-1:0] rdAddr,
  output logic [PW-1:0] rdGray,
  output logic          emptyN,
  output logic          almostEmptyN
);
  logic [PW-1:0] rdBin;
  logic [PW-1:0] rdBinNext;
  logic [PW-1:0] rdGrayNext;
  logic [PW-1:0] wrBinSync;
  logic [PW-1:0] rdLevel;

  assign rdCmd.read = rdEnA && rdEnB && emptyN;
  assign rdBinNext  = rdBin + PW'(rdCmd.read);
  assign rdGrayNext = (rdBinNext >> 1) ^ rdBinNext;
  assign rdAddr     = rdBin[AW-1:0];

  // Gray to binary for the write pointer seen in this domain
  always_comb begin
    for (int i = 0; i < PW; i++) begin
      wrBinSync[i] = ^(wrGraySync >> i);
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
      emptyN <= 1'b0;
    end else begin
      rdBin  <= rdBinNext;
      rdGray <= rdGrayNext;
      emptyN <= !(rdGrayNext == wrGraySync);
    end
  end

  // Threshold is quasi-static: it changes only during the load phase
  assign rdLevel      = wrBinSync - rdBin;
  assign almostEmptyN = !(rdLevel <= PW'(aeOff));

  a_r4_no_underflow: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |=> (rdBin == $past(rdBin)));

  a_r4_level_bound: assert property (@(posedge rdClk) disable iff (!rstN)
    rdLevel <= PW'(DEPTH));

  a_r7_empty_is_almost: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN);
endmodule

// File: rtl/fifo_pf_datapath.sv
module fifo_pf_datapath
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  wrCmd_t           wrCmd,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  rdCmd_t           rdCmd,
  input  logic [AW-1:0]    rdAddr,
  input  logic             outEn,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataValid
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] qReg;
  logic             validReg;

  always_ff @(posedge wrClk) begin
    if (wrCmd.write) begin
      mem[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      qReg     <= '0;
      validReg <= 1'b0;
    end else begin
      validReg <= rdCmd.read;
      if (rdCmd.read) begin
        qReg <= mem[rdAddr];
      end
    end
  end

  assign dataOut   = outEn ? qReg : '0;
  assign dataValid = outEn && validReg;

  a_r10_gate_quiet: assert property (@(posedge rdClk) disable iff (!rstN)
    !outEn |-> (!dataValid && dataOut == '0));
endmodule

// File: rtl/dcfifo_pf.sv
module dcfifo_pf
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] wrData,
  input  logic             wrEnA,
  input  logic             wrEnLd,
  output logic             fullN,
  output logic             almostFullN,
  input  logic             rdEnA,
  input  logic             rdEnB,
  input  logic             outEn,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataValid,
  output logic             emptyN,
  output logic             almostEmptyN
);
  wrCmd_t        wrCmd;
  rdCmd_t        rdCmd;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;
  logic [AW-1:0] aeOff;
  logic [PW-1:0] wrGray;
  logic [PW-1:0] rdGray;
  logic [PW-1:0] wrGraySync;
  logic [PW-1:0] rdGraySync;

  fifo_pf_sync2 #(.W(PW)) u_syncWr2Rd (
    .clk(rdClk), .rstN(rstN), .d(wrGray), .q(wrGraySync)
  );

  fifo_pf_sync2 #(.W(PW)) u_syncRd2Wr (
    .clk(wrClk), .rstN(rstN), .d(rdGray), .q(rdGraySync)
  );

  fifo_pf_wrctl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_wrctl (
    .wrClk(wrClk), .rstN(rstN), .wrEnA(wrEnA), .wrEnLd(wrEnLd),
    .wrData(wrData), .rdGraySync(rdGraySync), .wrCmd(wrCmd),
    .wrAddr(wrAddr), .wrGray(wrGray), .aeOff(aeOff),
    .fullN(fullN), .almostFullN(almostFullN)
  );

  fifo_pf_rdctl #(.DEPTH(DEPTH)) u_rdctl (
    .rdClk(rdClk), .rstN(rstN), .rdEnA(rdEnA), .rdEnB(rdEnB),
    .wrGraySync(wrGraySync), .aeOff(aeOff), .rdCmd(rdCmd),
    .rdAddr(rdAddr), .rdGray(rdGray), .emptyN(emptyN),
    .almostEmptyN(almostEmptyN)
  );

  fifo_pf_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrCmd(wrCmd),
    .wrAddr(wrAddr), .wrData(wrData), .rdCmd(rdCmd), .rdAddr(rdAddr),
    .outEn(outEn), .dataOut(dataOut), .dataValid(dataValid)
  );
endmodule

// File: tb/sim_dcfifo_pf.sv
module sim_dcfifo_pf;
  localparam int DEPTH = 512;

  logic       wrClk = 1'b0;
  logic       rdClk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] wrData = '0;
  logic       wrEnA = 1'b0;
  logic       wrEnLd = 1'b0;
  logic       rdEnA = 1'b0;
  logic       rdEnB = 1'b0;
  logic       outEn = 1'b1;
  logic       fullN, almostFullN, dataValid, emptyN, almostEmptyN;
  logic [8:0] dataOut;

  int checks = 0;
  int failures = 0;
  int wIdx = 0;
  int rIdx = 0;
  bit finished = 0;

  always #10 wrClk = ~wrClk;
  initial begin
    #7;
    forever #10 rdClk = ~rdClk;
  end

  dcfifo_pf #(.DEPTH(DEPTH), .WIDTH(9)) u0 (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrData(wrData),
    .wrEnA(wrEnA), .wrEnLd(wrEnLd), .fullN(fullN), .almostFullN(almostFullN),
    .rdEnA(rdEnA), .rdEnB(rdEnB), .outEn(outEn), .dataOut(dataOut),
    .dataValid(dataValid), .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  function automatic logic [8:0] pat(input int k);
    return 9'((k * 37 + 5) & 511);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge wrClk);
    repeat (5) @(negedge rdClk);
  endtask

  task automatic doReset(input logic ldLvl);
    @(negedge wrClk);
    rstN = 1'b0; wrEnA = 1'b0; wrEnLd = ldLvl; rdEnA = 1'b0; rdEnB = 1'b0; outEn = 1'b1;
    repeat (3) @(negedge wrClk);
    rstN = 1'b1;
    @(negedge wrClk);
    wrEnLd = 1'b0;
    wIdx = 0; rIdx = 0;
  endtask

  task automatic writeWords(input int n, input logic ldLvl);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      wrData = pat(wIdx); wrEnA = 1'b1; wrEnLd = ldLvl;
      wIdx++;
    end
    @(negedge wrClk);
    wrEnA = 1'b0; wrEnLd = 1'b0;
  endtask

  task automatic readWord(input string req);
    @(negedge rdClk);
    rdEnA = 1'b1; rdEnB = 1'b1;
    @(negedge rdClk);
    rdEnA = 1'b0; rdEnB = 1'b0;
    chk(req, {31'd0, dataValid}, 32'd1);
    chk(req, {23'd0, dataOut}, {23'd0, pat(rIdx)});
    rIdx++;
  endtask

  task automatic loadVal(input logic [8:0] v);
    @(negedge wrClk);
    wrData = v; wrEnA = 1'b1; wrEnLd = 1'b1;
    @(negedge wrClk);
    wrEnA = 1'b0; wrEnLd = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 emptyN in reset", {31'd0, emptyN}, 32'd0);
    chk("R1 fullN in reset", {31'd0, fullN}, 32'd1);
    doReset(1'b0);
    settle();
    chk("R1 emptyN", {31'd0, emptyN}, 32'd0);
    chk("R1 fullN", {31'd0, fullN}, 32'd1);
    chk("R1 almostEmptyN", {31'd0, almostEmptyN}, 32'd0);
    chk("R1 almostFullN", {31'd0, almostFullN}, 32'd1);
    chk("R1 dataValid", {31'd0, dataValid}, 32'd0);
  endtask

  task automatic testEnablesAndOrder();
    // R5: each write enable alone stores nothing
    @(negedge wrClk); wrData = 9'h111; wrEnA = 1'b1; wrEnLd = 1'b0;
    @(negedge wrClk); wrEnA = 1'b0; wrEnLd = 1'b1;
    @(negedge wrClk); wrEnLd = 1'b0;
    settle();
    chk("R5 single write enable", {31'd0, emptyN}, 32'd0);
    writeWords(5, 1'b1);
    settle();
    chk("R5 both enables store", {31'd0, emptyN}, 32'd1);
    // R6: each read enable alone fetches nothing
    @(negedge rdClk); rdEnA = 1'b1;
    @(negedge rdClk);
    chk("R6 rdEnA alone", {31'd0, dataValid}, 32'd0);
    rdEnA = 1'b0; rdEnB = 1'b1;
    @(negedge rdClk);
    chk("R6 rdEnB alone", {31'd0, dataValid}, 32'd0);
    rdEnB = 1'b0;
    for (int i = 0; i < 5; i++) readWord("R2 R11 order");
    settle();
    chk("R2 drained", {31'd0, emptyN}, 32'd0);
    // R4: read from empty
    @(negedge rdClk); rdEnA = 1'b1; rdEnB = 1'b1;
    @(negedge rdClk); rdEnA = 1'b0; rdEnB = 1'b0;
    chk("R4 read on empty", {31'd0, dataValid}, 32'd0);
    writeWords(1, 1'b1);
    settle();
    readWord("R4 pointer intact");
  endtask

  task automatic testAlmostEmpty();
    writeWords(7, 1'b1);
    settle();
    chk("R7 level 7", {31'd0, almostEmptyN}, 32'd0);
    writeWords(1, 1'b1);
    settle();
    chk("R7 level 8", {31'd0, almostEmptyN}, 32'd1);
    for (int i = 0; i < 8; i++) readWord("R2 drain");
  endtask

  task automatic testFull();
    doReset(1'b0);
    writeWords(DEPTH - 8, 1'b1);
    settle();
    chk("R8 level DEPTH-8", {31'd0, almostFullN}, 32'd1);
    writeWords(1, 1'b1);
    settle();
    chk("R8 level DEPTH-7", {31'd0, almostFullN}, 32'd0);
    chk("R3 not yet full", {31'd0, fullN}, 32'd1);
    writeWords(7, 1'b1);
    settle();
    chk("R3 full", {31'd0, fullN}, 32'd0);
    @(negedge wrClk); wrData = 9'h155; wrEnA = 1'b1; wrEnLd = 1'b1;
    @(negedge wrClk); wrEnA = 1'b0; wrEnLd = 1'b0;
    for (int i = 0; i < DEPTH; i++) readWord("R3 contents");
    settle();
    chk("R3 empty after drain", {31'd0, emptyN}, 32'd0);
  endtask

  task automatic testOutEnable();
    writeWords(3, 1'b1);
    settle();
    outEn = 1'b0;
    @(negedge rdClk); rdEnA = 1'b1; rdEnB = 1'b1;
    @(negedge rdClk); rdEnA = 1'b0; rdEnB = 1'b0;
    chk("R10 dataOut gated", {23'd0, dataOut}, 32'd0);
    chk("R10 dataValid gated", {31'd0, dataValid}, 32'd0);
    rIdx++;
    outEn = 1'b1;
    readWord("R10 pointer advanced");
    readWord("R11 next word");
  endtask

  task automatic testLoad();
    doReset(1'b1);
    loadVal(9'd2);
    loadVal(9'd10);
    loadVal(9'd5);
    settle();
    chk("R9 loads store nothing", {31'd0, emptyN}, 32'd0);
    writeWords(5, 1'b0);
    settle();
    chk("R9 wrapped ae threshold at 5", {31'd0, almostEmptyN}, 32'd0);
    writeWords(1, 1'b0);
    settle();
    chk("R9 ae threshold at 6", {31'd0, almostEmptyN}, 32'd1);
    writeWords(DEPTH - 11 - 6, 1'b0);
    settle();
    chk("R9 af below limit", {31'd0, almostFullN}, 32'd1);
    writeWords(1, 1'b0);
    settle();
    chk("R9 af at limit", {31'd0, almostFullN}, 32'd0);
    readWord("R9 load-mode data");
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    #25;
    testReset();
    testEnablesAndOrder();
    testAlmostEmpty();
    testFull();
    testOutEnable();
    testLoad();
    finishRun();
  end
endmodule